// File: doc/BRIEF.md
# Register-Transfer Destination Write Unit

This unit handles the write half of one register-to-register move in a 16-bit accumulator machine. A transfer arrives as a 7-bit destination code, a 16-bit source value and a flag that marks the source as a single byte. The unit decodes the code and applies the byte/word conversion rules. It then updates the addressed architectural register: one of sixteen accumulators, the accumulator pointer, the stack pointer, two loop counters, two data pointers, the frame base, the frame offset or the general register. For memory destinations it first adjusts the pointer the code names, if the code asks for that, and then emits one word write to data memory at the resulting address.

A one-shot prefix register sits inside the unit. A move to the prefix code stores a pending high byte and arms the prefix. The next defined move consumes it. While armed, the prefix supplies the high byte for byte-to-word moves, moves accumulator codes to the upper bank of eight, and turns one frame code into a high-byte write of the general register.

Both data paths use valid/ready handshakes. A transfer is taken on a clock edge where `in_valid` and `in_ready` are both high. The unit lowers `in_ready` for as long as its memory request is outstanding. A raised `mem_valid` holds its address and data unchanged until the memory raises `mem_ready`. The requester must keep a transfer on the inputs until it is taken, and the memory may stall for any number of cycles.

Top module: `mdw_top`

## Requirements
- R1: `in_ready` is high exactly when no memory request is outstanding. A transfer is taken on an edge with `in_valid && in_ready`, and its register effects are visible after that edge.
- R2: A word source moved to a word destination copies all 16 bits. Byte destinations (accumulator pointer, offset, general-register low or high byte) always take the source bits [7:0], whatever the source width.
- R3: A byte source moved to a word destination gets a high byte of 8'h00 when the prefix is not armed, and the pending prefix byte when it is.
- R4: Code 7'h0B loads source bits [7:0] as the pending byte and arms the prefix. Any later taken move whose code is defined, other than 7'h0B, disarms it.
- R5: Code {nnn,4'b1001} writes accumulator nnn, or accumulator 8+nnn when the prefix is armed. Code 7'h0A writes the accumulator selected by the pointer. Code 7'h08 with no prefix sets the pointer to source bits [3:0].
- R6: Code 7'h0D increments SP and then writes memory at the new SP. Code 7'h1D loads SP. Code {2'b11,n,4'b1101} loads loop counter n.
- R7: Codes 7'h0E, 7'h1E (no prefix) and 7'h2E write memory at BP + zero-extended offset, using the offset unchanged, pre-incremented or pre-decremented (8-bit wrap). Code 7'h3E loads the offset and 7'h7E loads BP.
- R8: Code {n,op,4'b1111} selects data pointer n. op 00 writes memory at DP[n], 01 pre-increments and then writes, 10 pre-decrements and then writes, 11 loads DP[n].
- R9: Code 7'h5E loads the whole general register. 7'h6E replaces only its low byte. 7'h1E with the prefix armed replaces only its high byte.
- R10: Code 7'h76 is a null destination. It changes no register, issues no memory write and disarms the prefix.
- R11: Every other code, including 7'h08 with the prefix armed, raises `err` for the one cycle after the edge that takes it. It changes no register, leaves the prefix as it was and issues no memory write.
- R12: While `mem_valid` is high and `mem_ready` low, `mem_valid`, `mem_addr` and `mem_wdata` hold their values, and no new transfer is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Transfer offered |
| in_ready | output | 1 | Transfer can be taken |
| in_dst | input | 7 | Destination code |
| in_src | input | 16 | Source value |
| in_src_byte | input | 1 | Source is a byte |
| mem_valid | output | 1 | Memory write request pending |
| mem_ready | input | 1 | Memory accepts the request |
| mem_addr | output | 16 | Word address |
| mem_wdata | output | 16 | Write data |
| err | output | 1 | Undefined code taken, one-cycle pulse |
| pfx_armed | output | 1 | Prefix pending |
| ap_q | output | 4 | Accumulator pointer |
| sp_q | output | 16 | Stack pointer |
| bp_q | output | 16 | Frame base |
| offs_q | output | 8 | Frame offset |
| gr_q | output | 16 | General register |
| dp0_q | output | 16 | Data pointer 0 |
| dp1_q | output | 16 | Data pointer 1 |
| lc0_q | output | 16 | Loop counter 0 |
| lc1_q | output | 16 | Loop counter 1 |
| acc_sel | input | 4 | Accumulator read select |
| acc_rdata | output | 16 | Selected accumulator value |

## Verification
The bench drives the offset past both ends of its 8-bit range through pre-increment and pre-decrement. A unit that carried into the frame base, or that wrote before it adjusted, would emit the wrong address. It checks that the prefix lands in the upper accumulator bank and that the prefix has disarmed by the next move; a sticky prefix would send that move to the wrong bank. It checks that an undefined code, including the pointer code reached with the prefix armed, neither disarms the prefix nor moves the pointer. It stalls the memory while a second transfer waits at the inputs, to catch a unit that takes the transfer early or lets the request drift.

// File: rtl/mdw_pkg.sv
package mdw_pkg;
  localparam int DATA_W   = 16;
  localparam int BYTE_W   = 8;
  localparam int OFFS_W   = 8;
  localparam int ACC_BANK = 8;
  localparam int ACC_N    = 2 * ACC_BANK;
  localparam int ACC_IW   = $clog2(ACC_N);
  localparam int CODE_W   = 7;
  localparam int PTR_N    = 2;

  typedef enum logic [3:0] {
    OP_ERR, OP_NUL, OP_ACC, OP_AP, OP_PFX, OP_SP, OP_PUSH, OP_LC,
    OP_FRM, OP_OFFS, OP_GR, OP_GRL, OP_GRH, OP_BP, OP_DPM, OP_DP
  } mdw_op_e;

  typedef enum logic [1:0] {ADJ_NONE, ADJ_INC, ADJ_DEC} mdw_adj_e;

  typedef struct packed {
    mdw_op_e             op;
    logic [ACC_IW-1:0]   acc_idx;
    logic                use_ap;
    logic                sel;
    mdw_adj_e            adj;
  } mdw_dec_t;
endpackage

// File: rtl/mdw_decode.sv
module mdw_decode
  import mdw_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic              pfx,
  output mdw_dec_t          dec
);
  logic [3:0] grp;
  logic [2:0] idx;

  assign grp = code[3:0];
  assign idx = code[6:4];

  always_comb begin
    dec         = '0;
    dec.op      = OP_ERR;
    dec.adj     = ADJ_NONE;
    dec.acc_idx = {pfx, idx};
    case (grp)
      4'b0110: if (idx == 3'b111) dec.op = OP_NUL;
      4'b1000: if (idx == 3'b000 && !pfx) dec.op = OP_AP;
      4'b1001: dec.op = OP_ACC;
      4'b1010: if (idx == 3'b000) begin
        dec.op     = OP_ACC;
        dec.use_ap = 1'b1;
      end
      4'b1011: if (idx == 3'b000) dec.op = OP_PFX;
      4'b1101: begin
        dec.sel = idx[0];
        case (idx)
          3'b000: begin dec.op = OP_PUSH; dec.adj = ADJ_INC; end
          3'b001: dec.op = OP_SP;
          3'b110, 3'b111: dec.op = OP_LC;
          default: dec.op = OP_ERR;
        endcase
      end
      4'b1110: begin
        case (idx)
          3'b000: dec.op = OP_FRM;
          3'b001: begin
            if (pfx) dec.op = OP_GRH;
            else begin dec.op = OP_FRM; dec.adj = ADJ_INC; end
          end
          3'b010: begin dec.op = OP_FRM; dec.adj = ADJ_DEC; end
          3'b011: dec.op = OP_OFFS;
          3'b101: dec.op = OP_GR;
          3'b110: dec.op = OP_GRL;
          3'b111: dec.op = OP_BP;
          default: dec.op = OP_ERR;
        endcase
      end
      4'b1111: begin
        dec.sel = idx[2];
        case (idx[1:0])
          2'b00: dec.op = OP_DPM;
          2'b01: begin dec.op = OP_DPM; dec.adj = ADJ_INC; end
          2'b10: begin dec.op = OP_DPM; dec.adj = ADJ_DEC; end
          default: dec.op = OP_DP;
        endcase
      end
      default: dec.op = OP_ERR;
    endcase
  end
endmodule

// File: rtl/mdw_acc_bank.sv
module mdw_acc_bank #(
  parameter int N  = mdw_pkg::ACC_N,
  parameter int W  = mdw_pkg::DATA_W,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] ridx,
  output logic [W-1:0]  rdata
);
  logic [N-1:0][W-1:0] flat;

  for (genvar g = 0; g < N; g++) begin : g_acc
    logic [W-1:0] r;
    always_ff @(posedge clk) begin
      if (!rst_n) r <= '0;
      else if (we && widx == IW'(g)) r <= wdata;
    end
    assign flat[g] = r;
  end

  assign rdata = flat[ridx];
endmodule

// File: rtl/mdw_memreq.sv
module mdw_memreq #(
  parameter int AW = mdw_pkg::DATA_W,
  parameter int DW = mdw_pkg::DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  input  logic          mem_ready,
  output logic          mem_valid,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_valid <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else if (load) begin
      mem_valid <= 1'b1;
      mem_addr  <= addr;
      mem_wdata <= data;
    end else if (mem_ready) begin
      mem_valid <= 1'b0;
    end
  end

  // R12
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_wdata));
endmodule

// File: rtl/mdw_top.sv
module mdw_top
  import mdw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CODE_W-1:0] in_dst,
  input  logic [DATA_W-1:0] in_src,
  input  logic              in_src_byte,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              err,
  output logic              pfx_armed,
  output logic [ACC_IW-1:0] ap_q,
  output logic [DATA_W-1:0] sp_q,
  output logic [DATA_W-1:0] bp_q,
  output logic [OFFS_W-1:0] offs_q,
  output logic [DATA_W-1:0] gr_q,
  output logic [DATA_W-1:0] dp0_q,
  output logic [DATA_W-1:0] dp1_q,
  output logic [DATA_W-1:0] lc0_q,
  output logic [DATA_W-1:0] lc1_q,
  input  logic [ACC_IW-1:0] acc_sel,
  output logic [DATA_W-1:0] acc_rdata
);
  localparam int HI_W = DATA_W - BYTE_W;

  mdw_dec_t                     dec;
  logic                         take;
  logic                         pfx_act;
  logic [BYTE_W-1:0]            pfx_hi;
  logic [ACC_IW-1:0]            ap;
  logic [DATA_W-1:0]            sp, bp, gr;
  logic [OFFS_W-1:0]            offs, offs_nx;
  logic [PTR_N-1:0][DATA_W-1:0] dp, lc;
  logic [DATA_W-1:0]            dp_nx, word, maddr;
  logic [BYTE_W-1:0]            byte_v;
  logic                         err_q, mload;

  mdw_decode u_dec (.code(in_dst), .pfx(pfx_act), .dec(dec));

  assign take   = in_valid && in_ready;
  assign in_ready = !mem_valid;
  assign byte_v = in_src[BYTE_W-1:0];
  assign word   = in_src_byte ? {(pfx_act ? pfx_hi : {HI_W{1'b0}}), byte_v} : in_src;

  always_comb begin
    case (dec.adj)
      ADJ_INC: begin offs_nx = offs + 1'b1; dp_nx = dp[dec.sel] + 1'b1; end
      ADJ_DEC: begin offs_nx = offs - 1'b1; dp_nx = dp[dec.sel] - 1'b1; end
      default: begin offs_nx = offs;        dp_nx = dp[dec.sel];        end
    endcase
  end

  always_comb begin
    mload = 1'b0;
    maddr = '0;
    if (take) begin
      case (dec.op)
        OP_PUSH: begin mload = 1'b1; maddr = sp + 1'b1; end
        OP_FRM:  begin mload = 1'b1; maddr = bp + {{(DATA_W-OFFS_W){1'b0}}, offs_nx}; end
        OP_DPM:  begin mload = 1'b1; maddr = dp_nx; end
        default: begin mload = 1'b0; maddr = '0; end
      endcase
    end
  end

  mdw_memreq u_mem (
    .clk(clk), .rst_n(rst_n), .load(mload), .addr(maddr), .data(word),
    .mem_ready(mem_ready), .mem_valid(mem_valid), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata)
  );

  mdw_acc_bank u_acc (
    .clk(clk), .rst_n(rst_n), .we(take && dec.op == OP_ACC),
    .widx(dec.use_ap ? ap : dec.acc_idx), .wdata(word),
    .ridx(acc_sel), .rdata(acc_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pfx_act <= 1'b0;
      pfx_hi  <= '0;
      ap      <= '0;
      sp      <= '0;
      bp      <= '0;
      gr      <= '0;
      offs    <= '0;
      dp      <= '0;
      lc      <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= take && dec.op == OP_ERR;
      if (take && dec.op == OP_PFX) begin
        pfx_hi  <= byte_v;
        pfx_act <= 1'b1;
      end else if (take && dec.op != OP_ERR) begin
        pfx_act <= 1'b0;
        case (dec.op)
          OP_AP:   ap <= in_src[ACC_IW-1:0];
          OP_SP:   sp <= word;
          OP_PUSH: sp <= sp + 1'b1;
          OP_LC:   lc[dec.sel] <= word;
          OP_BP:   bp <= word;
          OP_OFFS: offs <= byte_v;
          OP_FRM:  offs <= offs_nx;
          OP_GR:   gr <= word;
          OP_GRL:  gr[BYTE_W-1:0] <= byte_v;
          OP_GRH:  gr[DATA_W-1:BYTE_W] <= byte_v;
          OP_DP:   dp[dec.sel] <= word;
          OP_DPM:  dp[dec.sel] <= dp_nx;
          default: ;
        endcase
      end
    end
  end

  assign err       = err_q;
  assign pfx_armed = pfx_act;
  assign ap_q      = ap;
  assign sp_q      = sp;
  assign bp_q      = bp;
  assign offs_q    = offs;
  assign gr_q      = gr;
  assign dp0_q     = dp[0];
  assign dp1_q     = dp[1];
  assign lc0_q     = lc[0];
  assign lc1_q     = lc[1];

  // R11
  bad_code_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && dec.op == OP_ERR |=> err && !mem_valid && $stable(sp) && $stable(bp) &&
      $stable(offs) && $stable(gr) && $stable(ap) && $stable(pfx_act));
  // R6
  push_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && dec.op == OP_PUSH |=> sp == $past(sp) + 1'b1 && mem_valid && mem_addr == sp);
  // R4
  pfx_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && dec.op != OP_PFX && dec.op != OP_ERR |=> !pfx_armed);
  // R10
  null_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && dec.op == OP_NUL |=> !mem_valid && $stable(sp) && $stable(gr) && $stable(ap));
  // R7
  frame_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && dec.op == OP_FRM && dec.adj == ADJ_INC |=> offs == $past(offs) + 1'b1);
endmodule

// File: tb/mdw_top_tb.sv
`timescale 1ns/1ps
module mdw_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ready, in_src_byte = 1'b0;
  logic [6:0]  in_dst = '0;
  logic [15:0] in_src = '0;
  logic        mem_valid, mem_ready = 1'b0, err, pfx_armed;
  logic [15:0] mem_addr, mem_wdata, sp_q, bp_q, gr_q, dp0_q, dp1_q, lc0_q, lc1_q, acc_rdata;
  logic [7:0]  offs_q;
  logic [3:0]  ap_q, acc_sel = '0;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  mdw_top u_dut (.*);

  localparam logic [3:0] K_ACC = 4'd0, K_AP = 4'd1, K_PFX = 4'd2, K_SP = 4'd3,
    K_MEM = 4'd4, K_BP = 4'd5, K_OFFS = 4'd6, K_DP0 = 4'd7, K_DP1 = 4'd8,
    K_LC0 = 4'd9, K_LC1 = 4'd10, K_GR = 4'd11, K_ERR = 4'd12;
  localparam int NV = 28;
  // {req, dst, src_byte, src, kind, exp_a, exp_b}
  localparam logic [63:0] TBL [NV] = '{
    {4'd2,  7'h39, 1'b0, 16'h1234, K_ACC,  16'h1234, 16'h0003}, // R2
    {4'd5,  7'h08, 1'b1, 16'h00F5, K_AP,   16'h0005, 16'h0000}, // R5
    {4'd3,  7'h0A, 1'b1, 16'h00AB, K_ACC,  16'h00AB, 16'h0005}, // R3
    {4'd4,  7'h0B, 1'b0, 16'h77C3, K_PFX,  16'h0001, 16'h0000}, // R4
    {4'd5,  7'h29, 1'b1, 16'h0055, K_ACC,  16'hC355, 16'h000A}, // R5
    {4'd4,  7'h29, 1'b0, 16'hBEEF, K_ACC,  16'hBEEF, 16'h0002}, // R4
    {4'd6,  7'h1D, 1'b0, 16'h0100, K_SP,   16'h0100, 16'h0000}, // R6
    {4'd6,  7'h0D, 1'b0, 16'hCAFE, K_MEM,  16'h0101, 16'hCAFE}, // R6
    {4'd7,  7'h7E, 1'b0, 16'h2000, K_BP,   16'h2000, 16'h0000}, // R7
    {4'd2,  7'h3E, 1'b1, 16'h00FF, K_OFFS, 16'h00FF, 16'h0000}, // R2
    {4'd7,  7'h1E, 1'b0, 16'h1111, K_MEM,  16'h2000, 16'h1111}, // R7
    {4'd7,  7'h2E, 1'b1, 16'h0042, K_MEM,  16'h20FF, 16'h0042}, // R7
    {4'd7,  7'h0E, 1'b0, 16'h5A5A, K_MEM,  16'h20FF, 16'h5A5A}, // R7
    {4'd8,  7'h7F, 1'b0, 16'h3000, K_DP1,  16'h3000, 16'h0000}, // R8
    {4'd8,  7'h5F, 1'b0, 16'h0001, K_MEM,  16'h3001, 16'h0001}, // R8
    {4'd8,  7'h6F, 1'b0, 16'h0002, K_MEM,  16'h3000, 16'h0002}, // R8
    {4'd8,  7'h3F, 1'b0, 16'h4000, K_DP0,  16'h4000, 16'h0000}, // R8
    {4'd8,  7'h0F, 1'b0, 16'h9999, K_MEM,  16'h4000, 16'h9999}, // R8
    {4'd6,  7'h7D, 1'b0, 16'h0010, K_LC1,  16'h0010, 16'h0000}, // R6
    {4'd6,  7'h6D, 1'b0, 16'h0020, K_LC0,  16'h0020, 16'h0000}, // R6
    {4'd9,  7'h5E, 1'b0, 16'hA1B2, K_GR,   16'hA1B2, 16'h0000}, // R9
    {4'd9,  7'h6E, 1'b0, 16'h12C4, K_GR,   16'hA1C4, 16'h0000}, // R9
    {4'd4,  7'h0B, 1'b0, 16'h0000, K_PFX,  16'h0001, 16'h0000}, // R4
    {4'd9,  7'h1E, 1'b1, 16'h0039, K_GR,   16'h39C4, 16'h0000}, // R9
    {4'd11, 7'h12, 1'b0, 16'hFFFF, K_ERR,  16'h0000, 16'h0000}, // R11
    {4'd4,  7'h0B, 1'b0, 16'h00EE, K_PFX,  16'h0001, 16'h0000}, // R4
    {4'd11, 7'h4D, 1'b0, 16'h1234, K_ERR,  16'h0001, 16'h0000}, // R11
    {4'd10, 7'h76, 1'b0, 16'hABCD, K_PFX,  16'h0000, 16'h0000}  // R10
  };

  task automatic chk(input int req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic xfer(input logic [6:0] d, input logic sb, input logic [15:0] s);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_dst = d; in_src_byte = sb; in_src = s;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic take_mem(input int req, input logic [15:0] ea, input logic [15:0] ed);
    chk(req, "mem_valid", {15'd0, mem_valid}, 16'd1);
    chk(req, "mem_addr", mem_addr, ea);
    chk(req, "mem_wdata", mem_wdata, ed);
    mem_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    mem_ready = 1'b0;
    chk(1, "mem_valid after accept", {15'd0, mem_valid}, 16'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R1 watchdog act=timeout exp=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  logic [63:0] e;
  int          rq;
  logic [3:0]  kd;
  logic [15:0] ea, eb;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(1, "in_ready at reset", {15'd0, in_ready}, 16'd1);
    chk(1, "mem_valid at reset", {15'd0, mem_valid}, 16'd0);
    chk(11, "err at reset", {15'd0, err}, 16'd0);
    chk(6, "sp at reset", sp_q, 16'h0000);
    chk(4, "prefix at reset", {15'd0, pfx_armed}, 16'd0);

    for (int i = 0; i < NV; i++) begin
      e  = TBL[i];
      rq = int'(e[63:60]);
      kd = e[35:32];
      ea = e[31:16];
      eb = e[15:0];
      xfer(e[59:53], e[52], e[51:36]);
      case (kd)
        K_ACC: begin acc_sel = eb[3:0]; #1; chk(rq, "accumulator", acc_rdata, ea); end
        K_AP:   chk(rq, "ap", {12'd0, ap_q}, ea);
        K_PFX: begin
          chk(rq, "prefix", {15'd0, pfx_armed}, ea);
          chk(rq, "no mem/err", {14'd0, mem_valid, err}, 16'd0);
        end
        K_SP:   chk(rq, "sp", sp_q, ea);
        K_MEM:  take_mem(rq, ea, eb);
        K_BP:   chk(rq, "bp", bp_q, ea);
        K_OFFS: chk(rq, "offs", {8'd0, offs_q}, ea);
        K_DP0:  chk(rq, "dp0", dp0_q, ea);
        K_DP1:  chk(rq, "dp1", dp1_q, ea);
        K_LC0:  chk(rq, "lc0", lc0_q, ea);
        K_LC1:  chk(rq, "lc1", lc1_q, ea);
        K_GR:   chk(rq, "gr", gr_q, ea);
        default: begin
          chk(rq, "err pulse / no mem", {14'd0, err, mem_valid}, 16'h0002);
          chk(rq, "prefix kept", {15'd0, pfx_armed}, ea);
        end
      endcase
    end

    // R12 / R1: stalled memory with a second transfer waiting
    xfer(7'h0D, 1'b0, 16'hD00D);
    in_valid = 1'b1; in_dst = 7'h1D; in_src_byte = 1'b0; in_src = 16'hFFFF;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(12, "held mem_addr", mem_addr, 16'h0102);
      chk(12, "held mem_wdata", mem_wdata, 16'hD00D);
      chk(1, "in_ready while pending", {15'd0, in_ready}, 16'd0);
    end
    in_valid = 1'b0;
    chk(12, "sp untouched while stalled", sp_q, 16'h0102);
    take_mem(12, 16'h0102, 16'hD00D);

    // R11: pointer code with prefix armed is undefined
    xfer(7'h0B, 1'b0, 16'h0077);
    xfer(7'h08, 1'b1, 16'h000F);
    chk(11, "err on prefixed pointer code", {15'd0, err}, 16'd1);
    chk(11, "ap unchanged", {12'd0, ap_q}, 16'h0005);
    @(negedge clk);
    chk(11, "err lasts one cycle", {15'd0, err}, 16'd0);
    // R3: prefix byte reaches a word register
    xfer(7'h1D, 1'b1, 16'h0080);
    chk(3, "sp from byte with prefix", sp_q, 16'h7780);
    // R3: byte to word with no prefix
    xfer(7'h1D, 1'b1, 16'h0081);
    chk(3, "sp from byte, zero high", sp_q, 16'h0081);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule